// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a bank of 16-bit configuration words from a serial EEPROM as soon as reset is released. It drives a four-wire serial link with a chip select, a serial clock, a command and address line towards the memory, and a data line back from it. For every word it sends a read command and the word address, then shifts in sixteen data bits. The first bit received becomes the most significant bit of the word's slot. No host action is needed to start a load.

Two integrity checks run on the image while it streams in. The station-address check is a 16-bit additive check. It skips its own two bytes. The whole-image check is an 8-bit sum that must come out at FFh, and one adjust byte is reserved to make that happen. At the end the block reports both outcomes. If the image check fails, the bank falls back to default values. A busy level covers the whole load, including the gaps between words when the chip select drops. That makes busy, rather than the chip select, the signal to use for gating logic that depends on the load.

Top module: `eeld_cfg_loader`

## Requirements
- R1: Loading starts without any request once reset is released. `busy` is high from reset until the load completes. It falls in the same cycle that `done` goes high, and `done` is high for exactly one cycle.
- R2: Each word read raises `ee_cs` and puts nine header bits on `ee_di`, most significant first: the read opcode 1,1,0 followed by the 6-bit word address. `ee_di` only changes while `ee_sk` is low, and the memory samples it on the rising edge of `ee_sk`.
- R3: After the nine header edges, `ee_do` is sampled on the next sixteen rising edges of `ee_sk`. The first bit sampled goes to bit 15 of the slot and the last to bit 0. The word at address k goes to slot k, which is `cfg_words[16k+15:16k]`; for example, address 08h fills slot 8.
- R4: `ee_cs` returns low between consecutive words, so it rises once per word and NUM_WORDS times per load. `busy` stays high throughout those gaps.
- R5: Every high phase of `ee_sk` lasts DIV_HALF clock cycles. `ee_sk` is never high while `ee_cs` is low, and `ee_sk` and `ee_cs` both stay low once `busy` is low.
- R6: Words are read at addresses 0 through NUM_WORDS-1, in ascending order.
- R7: Word k holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Bytes 0Ch (low) and 0Dh (high) together hold a stored 16-bit value. `addr_err` is set at `done` when that value differs from the 16-bit sum of bytes 00h to 0Bh plus bytes 0Eh and 0Fh.
- R8: `img_err` is set at `done` when the 8-bit sum of all 2*NUM_WORDS bytes is not FFh. The adjust byte 1Fh takes part in this sum like any other byte.
- R9: When `img_err` is set, every slot k shows 16'hA500 + k from the `done` cycle on. When only `addr_err` is set, the loaded words are kept.
- R10: While reset is held, every slot k holds 16'hA500 + k. `done`, `addr_err`, `img_err`, `ee_cs`, `ee_sk` and `ee_di` are low and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a load |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Command and address bits to the EEPROM |
| ee_do | input | 1 | Data bits from the EEPROM |
| busy | output | 1 | High for the whole load |
| done | output | 1 | One-cycle pulse when the load ends |
| addr_err | output | 1 | Station-address check failed |
| img_err | output | 1 | Whole-image check failed, defaults applied |
| cfg_words | output | 16*NUM_WORDS | Configuration slots, slot k at bits 16k+15:16k |

## Verification
The last word's completion sets off three things that land on the same clock edge: the error flags are latched, the revert to defaults is applied if the image check fails, and `busy` falls together with the rise of `done`. The bench makes these collide by sweeping images that pass both checks, fail only one, or fail both. It samples the bank and the flags in the very cycle `done` is first seen high. The expected words, flags and reverted values are all recomputed there from the bytes the bench placed in the memory model.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 6;
    localparam int OP_W       = 3;
    localparam int HDR_BITS   = OP_W + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + WORD_W;

    localparam logic [OP_W-1:0] READ_OP = 3'b110;

    // word index holding the stored station-address sum, and last word covered
    localparam int ASUM_WORD = 6;
    localparam int ASUM_LAST = 7;

    localparam logic [7:0]  IMG_TARGET = 8'hFF;
    localparam logic [15:0] DFLT_BASE  = 16'hA500;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SQ_START,
        SQ_LOW,
        SQ_HIGH,
        SQ_GAP,
        SQ_FIN,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] idx;
        word_t             data;
    } word_evt_t;

    function automatic word_t dflt_word(input int unsigned k);
        return DFLT_BASE + word_t'(k);
    endfunction

    function automatic logic [HDR_BITS-1:0] read_header(input logic [ADDR_W-1:0] a);
        return {READ_OP, a};
    endfunction

    function automatic logic [7:0] bytes_sum8(input word_t w);
        return w[15:8] + w[7:0];
    endfunction

    function automatic logic [15:0] bytes_sum16(input word_t w);
        return {8'h00, w[15:8]} + {8'h00, w[7:0]};
    endfunction

endpackage

// File: rtl/eeld_tick.sv
module eeld_tick #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == CNT_LAST);

    generate
        if (DIV_HALF > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R5
        end
    endgenerate

endmodule

// File: rtl/eeld_seq.sv
module eeld_seq
    import eeld_pkg::*;
#(
    parameter int NUM_WORDS = 18
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      ee_do,
    output logic      ee_cs,
    output logic      ee_sk,
    output logic      ee_di,
    output word_evt_t evt,
    output logic      fin,
    output logic      busy
);
    localparam int BC_W = $clog2(FRAME_BITS);
    localparam logic [BC_W-1:0]   BIT_LAST  = BC_W'(FRAME_BITS - 1);
    localparam logic [BC_W-1:0]   BIT_DATA0 = BC_W'(HDR_BITS);
    localparam logic [ADDR_W-1:0] WORD_LAST = ADDR_W'(NUM_WORDS - 1);

    seq_state_e        st_q;
    logic [BC_W-1:0]   bit_q;
    logic [ADDR_W-1:0] widx_q;
    word_t             sr_q;
    logic              cs_q;
    logic              sk_q;
    logic              evt_v_q;
    logic [HDR_BITS-1:0] hdr_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_START;
            bit_q   <= '0;
            widx_q  <= '0;
            sr_q    <= '0;
            cs_q    <= 1'b0;
            sk_q    <= 1'b0;
            evt_v_q <= 1'b0;
        end else begin
            evt_v_q <= 1'b0;
            case (st_q)
                SQ_START: if (tick) begin
                    cs_q  <= 1'b1;
                    bit_q <= '0;
                    st_q  <= SQ_LOW;
                end
                SQ_LOW: if (tick) begin
                    sk_q <= 1'b1;
                    if (bit_q >= BIT_DATA0) begin
                        sr_q <= {sr_q[WORD_W-2:0], ee_do};
                    end
                    st_q <= SQ_HIGH;
                end
                SQ_HIGH: if (tick) begin
                    sk_q <= 1'b0;
                    if (bit_q == BIT_LAST) begin
                        cs_q    <= 1'b0;
                        evt_v_q <= 1'b1;
                        st_q    <= SQ_GAP;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        st_q  <= SQ_LOW;
                    end
                end
                SQ_GAP: if (tick) begin
                    if (widx_q == WORD_LAST) begin
                        st_q <= SQ_FIN;
                    end else begin
                        widx_q <= widx_q + 1'b1;
                        bit_q  <= '0;
                        cs_q   <= 1'b1;
                        st_q   <= SQ_LOW;
                    end
                end
                SQ_FIN:  st_q <= SQ_DONE;
                default: st_q <= SQ_DONE;
            endcase
        end
    end

    always_comb begin
        hdr_sh = read_header(widx_q) << bit_q;
        ee_di  = 1'b0;
        if ((st_q == SQ_LOW || st_q == SQ_HIGH) && bit_q < BIT_DATA0) begin
            ee_di = hdr_sh[HDR_BITS-1];
        end
    end

    assign ee_cs     = cs_q;
    assign ee_sk     = sk_q;
    assign evt.valid = evt_v_q;
    assign evt.idx   = widx_q;
    assign evt.data  = sr_q;
    assign fin       = (st_q == SQ_FIN);
    assign busy      = (st_q != SQ_DONE);

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_sk); // R5
    AST_DI_SETTLED: assert property (@(posedge clk) disable iff (rst)
        !$stable(ee_di) |-> !ee_sk); // R2
    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_q <= BIT_LAST); // R3
    AST_BUSY_UNTIL_FIN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fin)); // R1

endmodule

// File: rtl/eeld_csum.sv
module eeld_csum
    import eeld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt,
    output logic      addr_bad,
    output logic      img_bad
);
    localparam logic [ADDR_W-1:0] STORE_IDX = ADDR_W'(ASUM_WORD);
    localparam logic [ADDR_W-1:0] SPAN_IDX  = ADDR_W'(ASUM_LAST);

    logic [7:0]  img_acc_q;
    logic [15:0] addr_acc_q;
    logic [15:0] stored_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            img_acc_q  <= '0;
            addr_acc_q <= '0;
            stored_q   <= '0;
        end else if (evt.valid) begin
            img_acc_q <= img_acc_q + bytes_sum8(evt.data);
            if (evt.idx == STORE_IDX) begin
                stored_q <= evt.data;
            end else if (evt.idx <= SPAN_IDX) begin
                addr_acc_q <= addr_acc_q + bytes_sum16(evt.data);
            end
        end
    end

    assign addr_bad = (addr_acc_q != stored_q);
    assign img_bad  = (img_acc_q != IMG_TARGET);

    AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !evt.valid |=> ($stable(img_acc_q) && $stable(addr_acc_q) && $stable(stored_q))); // R8

endmodule

// File: rtl/eeld_bank.sv
module eeld_bank
    import eeld_pkg::*;
#(
    parameter int NUM_WORDS = 18
) (
    input  logic                        clk,
    input  logic                        rst,
    input  word_evt_t                   evt,
    input  logic                        revert,
    output logic [NUM_WORDS*WORD_W-1:0] words
);
    logic [NUM_WORDS*WORD_W-1:0] dflt_vec;

    always_comb begin
        for (int k = 0; k < NUM_WORDS; k++) begin
            dflt_vec[k*WORD_W +: WORD_W] = dflt_word(k);
        end
    end

    generate
        for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slot
            word_t slot_q;
            always_ff @(posedge clk) begin
                if (rst || revert) begin
                    slot_q <= dflt_word(k);
                end else if (evt.valid && evt.idx == ADDR_W'(k)) begin
                    slot_q <= evt.data;
                end
            end
            assign words[k*WORD_W +: WORD_W] = slot_q;
        end
    endgenerate

    AST_REVERT_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        revert |=> (words == dflt_vec)); // R9

endmodule

// File: rtl/eeld_cfg_loader.sv
module eeld_cfg_loader
    import eeld_pkg::*;
#(
    parameter int NUM_WORDS = 18,
    parameter int DIV_HALF  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic                    ee_cs,
    output logic                    ee_sk,
    output logic                    ee_di,
    input  logic                    ee_do,
    output logic                    busy,
    output logic                    done,
    output logic                    addr_err,
    output logic                    img_err,
    output logic [NUM_WORDS*16-1:0] cfg_words
);
    initial begin
        if (NUM_WORDS < ASUM_LAST + 1 || NUM_WORDS > (1 << ADDR_W)) begin
            $error("NUM_WORDS out of range");
        end
        if (DIV_HALF < 1) begin
            $error("DIV_HALF must be at least 1");
        end
    end

    logic      tick;
    logic      fin;
    logic      busy_w;
    logic      addr_bad;
    logic      img_bad;
    word_evt_t evt;
    logic      done_q;
    logic      aerr_q;
    logic      ierr_q;

    eeld_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (busy_w),
        .tick (tick)
    );

    eeld_seq #(.NUM_WORDS(NUM_WORDS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .ee_do (ee_do),
        .ee_cs (ee_cs),
        .ee_sk (ee_sk),
        .ee_di (ee_di),
        .evt   (evt),
        .fin   (fin),
        .busy  (busy_w)
    );

    eeld_csum u_csum (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_bad (addr_bad),
        .img_bad  (img_bad)
    );

    eeld_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .revert (fin && img_bad),
        .words  (cfg_words)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            aerr_q <= 1'b0;
            ierr_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) begin
                aerr_q <= addr_bad;
                ierr_q <= img_bad;
            end
        end
    end

    assign busy     = busy_w;
    assign done     = done_q;
    assign addr_err = aerr_q;
    assign img_err  = ierr_q;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R1
    AST_LINES_PARKED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk)); // R5

endmodule

// File: tb/eeld_cfg_loader_bench.sv
module eeld_cfg_loader_bench;
    localparam int NW = 18;
    localparam int DH = 2;
    localparam int NB = 2 * NW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ee_cs, ee_sk, ee_di;
    logic ee_do = 1'b0;
    logic busy, done, addr_err, img_err;
    logic [NW*16-1:0] cfg_words;

    always #4 clk = ~clk;

    eeld_cfg_loader #(.NUM_WORDS(NW), .DIV_HALF(DH)) u_eeld_cfg_loader (
        .clk       (clk),
        .rst       (rst),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di),
        .ee_do     (ee_do),
        .busy      (busy),
        .done      (done),
        .addr_err  (addr_err),
        .img_err   (img_err),
        .cfg_words (cfg_words)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [7:0]  img [NB];
    logic [15:0] mem [NW];

    // memory model
    int         rcnt     = 0;
    logic [8:0] hdr      = '0;
    int         frames   = 0;
    int         hdr_bad  = 0;
    int         cs_rises = 0;

    always @(posedge ee_cs) begin
        rcnt = 0;
        hdr  = '0;
        cs_rises++;
    end

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            rcnt++;
            if (rcnt <= 9) hdr = {hdr[7:0], ee_di};
            if (rcnt == 9) begin
                if (hdr[8:6] != 3'b110 || int'(hdr[5:0]) != frames) hdr_bad++;
                frames++;
            end
        end
    end

    always @(negedge ee_sk) begin
        if (ee_cs && rcnt >= 9 && rcnt <= 24 && int'(hdr[5:0]) < NW) begin
            ee_do = mem[hdr[5:0]][24 - rcnt];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int c);
        logic [15:0] asum;
        logic [15:0] stored;
        logic [7:0]  isum;
        bit          exp_a;
        bit          exp_i;
        int          cyc;
        int          hi_run;
        int          sk_bad;
        int          busy_bad;
        bit          seen_done;
        bit          prev_busy;
        logic [15:0] exp_w;

        for (int i = 0; i < NB; i++) begin
            img[i] = 8'((c * 53 + i * 29 + 7) ^ (i << (c % 3)));
        end
        asum = '0;
        for (int i = 0; i < 16; i++) begin
            if (i != 12 && i != 13) asum = asum + 16'(img[i]);
        end
        stored = asum ^ ((c % 2 == 1) ? 16'h0100 : 16'h0000);
        img[12] = stored[7:0];
        img[13] = stored[15:8];
        isum = '0;
        for (int i = 0; i < NB; i++) begin
            if (i != 31) isum = isum + img[i];
        end
        img[31] = 8'hFF - isum;
        if ((c / 2) % 2 == 1) img[31] = img[31] + 8'h01;
        for (int k = 0; k < NW; k++) mem[k] = {img[2*k+1], img[2*k]};

        // expected verdicts recomputed from the final image
        asum = '0;
        for (int i = 0; i < 16; i++) begin
            if (i != 12 && i != 13) asum = asum + 16'(img[i]);
        end
        exp_a = (asum != {img[13], img[12]});
        isum = '0;
        for (int i = 0; i < NB; i++) isum = isum + img[i];
        exp_i = (isum != 8'hFF);

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        frames = 0; hdr_bad = 0; cs_rises = 0;
        // R10 reset state
        chk(busy == 1'b1 && done == 1'b0, "R10", "busy/done in reset", {busy, done}, 2'b10);
        chk(!addr_err && !img_err, "R10", "flags in reset", {addr_err, img_err}, 0);
        chk(!ee_cs && !ee_sk && !ee_di, "R10", "lines in reset", {ee_cs, ee_sk, ee_di}, 0);
        for (int k = 0; k < NW; k++) begin
            chk(cfg_words[k*16 +: 16] == 16'hA500 + 16'(k), "R10", "slot default",
                cfg_words[k*16 +: 16], 16'hA500 + 16'(k));
        end
        rst = 1'b0;

        cyc = 0; hi_run = 0; sk_bad = 0; busy_bad = 0; seen_done = 0; prev_busy = 1;
        while (!seen_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (ee_sk) begin
                hi_run++;
            end else if (hi_run != 0) begin
                if (hi_run != DH) sk_bad++;
                hi_run = 0;
            end
            if (!ee_cs && ee_sk) sk_bad++;
            if (done) begin
                seen_done = 1;
                // R1: busy falls in the done cycle; R7/R8/R9 judged in this same cycle
                chk(!busy && prev_busy, "R1", "busy edge at done", {prev_busy, busy}, 2'b10);
                chk(addr_err == exp_a, "R7", "addr_err", addr_err, exp_a);
                chk(img_err == exp_i, "R8", "img_err", img_err, exp_i);
                for (int k = 0; k < NW; k++) begin
                    exp_w = exp_i ? (16'hA500 + 16'(k)) : {img[2*k+1], img[2*k]};
                    chk(cfg_words[k*16 +: 16] == exp_w, exp_i ? "R9" : "R3", "slot",
                        cfg_words[k*16 +: 16], exp_w);
                end
            end else if (!busy) begin
                busy_bad++;
            end
            prev_busy = busy;
        end
        if (!seen_done) chk(1'b0, "R1", "watchdog: no done", cyc, 0);

        chk(busy_bad == 0, "R4", "busy low before done", busy_bad, 0);
        chk(hdr_bad == 0, "R2", "read headers", hdr_bad, 0);
        chk(frames == NW, "R6", "frames addressed", frames, NW);
        chk(cs_rises == NW, "R4", "chip select rises", cs_rises, NW);
        chk(sk_bad == 0, "R5", "clock phase faults", sk_bad, 0);

        @(negedge clk);
        chk(!done, "R1", "done width", done, 0);
        chk(!busy && !ee_cs && !ee_sk, "R5", "lines parked", {busy, ee_cs, ee_sk}, 0);
        if (exp_a && !exp_i) begin
            chk(cfg_words[7*16 +: 16] == {img[15], img[14]}, "R9", "kept on addr-only fail",
                cfg_words[7*16 +: 16], {img[15], img[14]});
        end
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: run did not end");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) run_case(c);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule